// File: doc/BRIEF.md
# Routed Event Interrupt Aggregator

The block collects single-cycle event pulses from peripherals and latches each one into a bit of a set of status words. Three interrupt lines each have their own bank of enable words, with one bank per line. A latched event reaches a line only while that line's enable bit for the event is set. An event can therefore be routed to none, one, two or all three lines. A line stays high as long as any enabled event on it remains pending. Software acknowledges an event by writing a one to its status bit.

Each line also has a helper output, the priority index. It gives the number of the lowest-numbered pending event that is enabled on that line, together with a valid flag. A handler can read that index instead of scanning the status and enable words itself. Software reaches the registers through a plain word-wide write/read port that takes byte offsets. Reads are combinational.

With the defaults there are 96 events, held as three 32-bit status words, and three lines. Event `e` lives in status word `e/32` at bit `e%32`.

Top module: `evt_irq_aggregator`

## Requirements
- R1: On reset, every status and enable word reads zero, all lines are low and every valid flag is low.
- R2: A one on event input `e` sets bit `e%32` of the status word at offset `4*(e/32)`. The bit stays set, with the pulse gone, until it is acknowledged.
- R3: A write to a status word clears each bit written as one and leaves each bit written as zero unchanged.
- R4: If an event pulse arrives in the same cycle as a write that clears that same bit, the bit ends up set.
- R5: The enable word for line `g` (0..2) and status word `w` (0..2) sits at offset `0x10 + 0x10*g + 4*w`. It reads back the last value written to it.
- R6: Line `g` is high exactly while some status bit is set whose bit in line `g`'s enable bank is also set. Status bits that are not enabled never raise a line.
- R7: When line `g` is high, its valid flag is high and its 7-bit index (bits `7g+6:7g` of the index bus) holds the lowest event number that is both pending and enabled for `g`. When the line is low, the valid flag is low.
- R8: Reads of offsets that map to no register return zero, and so do reads of offsets that are not word-aligned. Writes to any such offset change no register.
- R9: A write to one status word leaves the other status words unchanged.
- R10: A single event enabled in several banks raises each of those lines, and only those lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| events_i | input | 96 | Event pulses, bit `e` is event `e` |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset of the register accessed |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 3 | Interrupt lines, level |
| irq_idx_o | output | 21 | Priority index per line, 7 bits each |
| irq_vld_o | output | 3 | Index valid flag per line |

## Verification
Status and enable words change at the rising edge that samples an event pulse or a write strobe. The lines, the indices and the valid flags follow from those registers through logic alone, so they are correct just after that same edge. Read data depends only on the address and on the registers, so it is correct within the same cycle.

The bench drives every input on the falling edge. It samples the lines and indices 1 ns after the next rising edge. It reads registers by setting an address on a falling edge and sampling 1 ns later. No check therefore waits an extra cycle, and no check samples before the capturing edge.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        REG_NONE   = 2'd0,
        REG_STATUS = 2'd1,
        REG_ENABLE = 2'd2
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [3:0] grp;
        logic [1:0] word;
    } reg_sel_t;

    // Offsets are split into 16-byte blocks: block 0 holds the status
    // words, block g+1 holds the enable bank of line g.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int n_words,
                                             input int n_lines);
        reg_sel_t s;
        s.kind = REG_NONE;
        s.grp  = '0;
        s.word = a[3:2];
        if (a[1:0] == 2'b00 && int'(a[3:2]) < n_words) begin
            if (a[7:4] == 4'd0) begin
                s.kind = REG_STATUS;
            end else if (int'(a[7:4]) <= n_lines) begin
                s.kind = REG_ENABLE;
                s.grp  = a[7:4] - 4'd1;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
    parameter int  NUM_WORDS = 3,
    parameter int  WORD_W    = 32,
    localparam int NUM_EVT   = NUM_WORDS * WORD_W
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [NUM_EVT-1:0]                   events_i,
    input  logic                                 clr_en_i,
    input  logic [1:0]                           clr_word_i,
    input  logic [WORD_W-1:0]                    clr_bits_i,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]     status_o
);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] bits;
    } status_st_t;

    status_st_t st_d;
    status_st_t st_q;

    always_comb begin
        st_d = st_q;
        for (int w = 0; w < NUM_WORDS; w++) begin
            logic [WORD_W-1:0] clr;
            clr = (clr_en_i && clr_word_i == 2'(w)) ? clr_bits_i : '0;
            // a new pulse is ORed after the clear so it always survives
            st_d.bits[w] = (st_q.bits[w] & ~clr) | events_i[w*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.bits;

endmodule

// File: rtl/evt_enable_bank.sv
module evt_enable_bank #(
    parameter int NUM_WORDS = 3,
    parameter int WORD_W    = 32,
    parameter int NUM_LINES = 3
) (
    input  logic                                              clk,
    input  logic                                              rst_n,
    input  logic                                              wr_en_i,
    input  logic [3:0]                                        wr_grp_i,
    input  logic [1:0]                                        wr_word_i,
    input  logic [WORD_W-1:0]                                 wr_data_i,
    output logic [NUM_LINES-1:0][NUM_WORDS-1:0][WORD_W-1:0]   enable_o
);

    typedef struct packed {
        logic [NUM_LINES-1:0][NUM_WORDS-1:0][WORD_W-1:0] en;
    } enable_st_t;

    enable_st_t en_d;
    enable_st_t en_q;

    always_comb begin
        en_d = en_q;
        for (int g = 0; g < NUM_LINES; g++) begin
            for (int w = 0; w < NUM_WORDS; w++) begin
                if (wr_en_i && wr_grp_i == 4'(g) && wr_word_i == 2'(w)) begin
                    en_d.en[g][w] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign enable_o = en_q.en;

endmodule

// File: rtl/evt_line_arbiter.sv
module evt_line_arbiter #(
    parameter int  NUM_EVT = 96,
    localparam int IDX_W   = $clog2(NUM_EVT)
) (
    input  logic [NUM_EVT-1:0] pend_i,
    output logic               req_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               vld_o
);

    assign req_o = |pend_i;

    // scan downwards so the lowest set bit is the last one to assign
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                vld_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/evt_irq_aggregator.sv
module evt_irq_aggregator
    import evt_irq_pkg::*;
#(
    parameter int  NUM_WORDS = 3,
    parameter int  WORD_W    = 32,
    parameter int  NUM_LINES = 3,
    localparam int NUM_EVT   = NUM_WORDS * WORD_W,
    localparam int IDX_W     = $clog2(NUM_EVT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_EVT-1:0]         events_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [WORD_W-1:0]          wdata_i,
    output logic [WORD_W-1:0]          rdata_o,
    output logic [NUM_LINES-1:0]       irq_o,
    output logic [NUM_LINES*IDX_W-1:0] irq_idx_o,
    output logic [NUM_LINES-1:0]       irq_vld_o
);

    reg_sel_t sel;
    logic     status_clr;
    logic     enable_wr;

    logic [NUM_WORDS-1:0][WORD_W-1:0]                 status_q;
    logic [NUM_LINES-1:0][NUM_WORDS-1:0][WORD_W-1:0]  enable_q;
    logic [NUM_EVT-1:0]                               status_vec;
    logic [NUM_LINES-1:0][NUM_EVT-1:0]                enable_vec;

    always_comb begin
        sel        = decode_addr(addr_i, NUM_WORDS, NUM_LINES);
        status_clr = wr_en_i && (sel.kind == REG_STATUS);
        enable_wr  = wr_en_i && (sel.kind == REG_ENABLE);
    end

    evt_status_bank #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .events_i   (events_i),
        .clr_en_i   (status_clr),
        .clr_word_i (sel.word),
        .clr_bits_i (wdata_i),
        .status_o   (status_q)
    );

    evt_enable_bank #(
        .NUM_WORDS (NUM_WORDS),
        .WORD_W    (WORD_W),
        .NUM_LINES (NUM_LINES)
    ) u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (enable_wr),
        .wr_grp_i  (sel.grp),
        .wr_word_i (sel.word),
        .wr_data_i (wdata_i),
        .enable_o  (enable_q)
    );

    assign status_vec = status_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [NUM_EVT-1:0] pend;

        assign enable_vec[g] = enable_q[g];
        assign pend          = status_vec & enable_vec[g];

        evt_line_arbiter #(
            .NUM_EVT (NUM_EVT)
        ) u_arb (
            .pend_i (pend),
            .req_o  (irq_o[g]),
            .idx_o  (irq_idx_o[g*IDX_W +: IDX_W]),
            .vld_o  (irq_vld_o[g])
        );
    end

    always_comb begin
        rdata_o = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (sel.kind == REG_STATUS && sel.word == 2'(w)) begin
                rdata_o = status_q[w];
            end
            for (int g = 0; g < NUM_LINES; g++) begin
                if (sel.kind == REG_ENABLE && sel.grp == 4'(g) && sel.word == 2'(w)) begin
                    rdata_o = enable_q[g][w];
                end
            end
        end
    end

endmodule

// File: rtl/evt_irq_aggregator_chk.sv
module evt_irq_aggregator_chk
    import evt_irq_pkg::*;
#(
    parameter int  NUM_WORDS = 3,
    parameter int  WORD_W    = 32,
    parameter int  NUM_LINES = 3,
    localparam int NUM_EVT   = NUM_WORDS * WORD_W,
    localparam int IDX_W     = $clog2(NUM_EVT)
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic [NUM_EVT-1:0]                events_i,
    input logic                              wr_en_i,
    input logic [ADDR_W-1:0]                 addr_i,
    input logic [WORD_W-1:0]                 wdata_i,
    input logic [NUM_EVT-1:0]                status_vec,
    input logic [NUM_LINES-1:0][NUM_EVT-1:0] enable_vec,
    input logic [NUM_LINES-1:0]              irq_o,
    input logic [NUM_LINES*IDX_W-1:0]        irq_idx_o,
    input logic [NUM_LINES-1:0]              irq_vld_o
);

    AST_EVENT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|events_i) |=> ((status_vec & $past(events_i)) == $past(events_i))); // R4

    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && !(|events_i)) |=> $stable(status_vec)); // R2

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && addr_i == ADDR_W'(w * 4) && events_i[w*WORD_W +: WORD_W] == '0)
            |=> ((status_vec[w*WORD_W +: WORD_W] & $past(wdata_i)) == '0)); // R3
    end

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic [NUM_EVT-1:0] pend;
        logic [IDX_W-1:0]   idx;
        logic [NUM_EVT-1:0] below;

        assign pend  = status_vec & enable_vec[g];
        assign idx   = irq_idx_o[g*IDX_W +: IDX_W];
        assign below = (NUM_EVT'(1) << idx) - NUM_EVT'(1);

        AST_LINE_VALID_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[g] == irq_vld_o[g]); // R6

        AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_vld_o[g] |-> (int'(idx) < NUM_EVT)); // R7

        AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
            irq_vld_o[g] |-> (pend[idx] && (pend & below) == '0)); // R7
    end

endmodule

bind evt_irq_aggregator evt_irq_aggregator_chk #(
    .NUM_WORDS (NUM_WORDS),
    .WORD_W    (WORD_W),
    .NUM_LINES (NUM_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .events_i   (events_i),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .status_vec (status_vec),
    .enable_vec (enable_vec),
    .irq_o      (irq_o),
    .irq_idx_o  (irq_idx_o),
    .irq_vld_o  (irq_vld_o)
);

// File: tb/tb_evt_irq_aggregator.sv
`timescale 1ns/1ps
module tb_evt_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] events_i = '0;
    logic        wr_en_i = 1'b0;
    logic [7:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic [2:0]  irq_o;
    logic [20:0] irq_idx_o;
    logic [2:0]  irq_vld_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    evt_irq_aggregator dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .events_i  (events_i),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .irq_o     (irq_o),
        .irq_idx_o (irq_idx_o),
        .irq_vld_o (irq_vld_o)
    );

    typedef struct packed {
        logic [6:0] ea;
        logic [6:0] eb;
        logic [2:0] ma;
        logic [2:0] mb;
        logic [2:0] exp_irq;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{7'd5,  7'd40, 3'b001, 3'b001, 3'b001},
        '{7'd95, 7'd64, 3'b100, 3'b010, 3'b110},
        '{7'd31, 7'd32, 3'b011, 3'b110, 3'b111},
        '{7'd0,  7'd70, 3'b000, 3'b000, 3'b000},
        '{7'd63, 7'd10, 3'b111, 3'b100, 3'b111},
        '{7'd48, 7'd48, 3'b010, 3'b000, 3'b010}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic [95:0] ev, input logic we,
                        input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        events_i = ev;
        wr_en_i  = we;
        addr_i   = a;
        wdata_i  = d;
        @(posedge clk);
        #1;
        events_i = '0;
        wr_en_i  = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        wr_en_i  = 1'b0;
        events_i = '0;
        addr_i   = a;
        #1;
        d = rdata_o;
    endtask

    function automatic logic [7:0] en_addr(input int g, input int w);
        return 8'(16 + 16 * g + 4 * w);
    endfunction

    function automatic logic [95:0] one_evt(input int e);
        logic [95:0] v;
        v = '0;
        v[e] = 1'b1;
        return v;
    endfunction

    task automatic clear_all();
        for (int w = 0; w < 3; w++) step('0, 1'b1, 8'(4 * w), 32'hFFFF_FFFF);
        for (int g = 0; g < 3; g++)
            for (int w = 0; w < 3; w++) step('0, 1'b1, en_addr(g, w), 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] en_w [3][3];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R1: reset state
        chk("R1 irq", 32'(irq_o), 32'h0);
        chk("R1 vld", 32'(irq_vld_o), 32'h0);
        for (int w = 0; w < 3; w++) begin
            rd(8'(4 * w), d);
            chk("R1 status", d, 32'h0);
            for (int g = 0; g < 3; g++) begin
                rd(en_addr(g, w), d);
                chk("R1 enable", d, 32'h0);
            end
        end

        // table of routing vectors: R2, R6, R7, R10
        for (int i = 0; i < 6; i++) begin
            vec_t v;
            v = VECS[i];
            clear_all();
            for (int g = 0; g < 3; g++)
                for (int w = 0; w < 3; w++) en_w[g][w] = 32'h0;
            for (int g = 0; g < 3; g++) begin
                if (v.ma[g]) en_w[g][int'(v.ea) / 32][int'(v.ea) % 32] = 1'b1;
                if (v.mb[g]) en_w[g][int'(v.eb) / 32][int'(v.eb) % 32] = 1'b1;
            end
            for (int g = 0; g < 3; g++)
                for (int w = 0; w < 3; w++) step('0, 1'b1, en_addr(g, w), en_w[g][w]);
            step(one_evt(int'(v.ea)) | one_evt(int'(v.eb)), 1'b0, 8'h0, 32'h0);
            chk("R6 R10 lines", 32'(irq_o), 32'(v.exp_irq));
            for (int g = 0; g < 3; g++) begin
                int best;
                best = -1;
                if (v.ma[g]) best = int'(v.ea);
                if (v.mb[g] && (best < 0 || int'(v.eb) < best)) best = int'(v.eb);
                chk("R7 vld", 32'(irq_vld_o[g]), (best >= 0) ? 32'h1 : 32'h0);
                if (best >= 0) chk("R7 idx", 32'(irq_idx_o[g*7 +: 7]), 32'(best));
            end
            rd(8'(4 * (int'(v.ea) / 32)), d);
            chk("R2 status bit", 32'(d[int'(v.ea) % 32]), 32'h1);
        end

        // R3: write-one clears, zero keeps
        clear_all();
        step(one_evt(3) | one_evt(7), 1'b0, 8'h0, 32'h0);
        step('0, 1'b1, 8'h00, 32'h0000_0008);
        rd(8'h00, d);
        chk("R3 w1c", d, 32'h0000_0080);
        step('0, 1'b1, 8'h00, 32'h0);
        rd(8'h00, d);
        chk("R3 zero keeps", d, 32'h0000_0080);

        // R4: pulse and clear of the same bit in one cycle
        step(one_evt(7), 1'b1, 8'h00, 32'h0000_0080);
        rd(8'h00, d);
        chk("R4 set wins", d, 32'h0000_0080);
        step(one_evt(9), 1'b1, 8'h00, 32'h0000_0280);
        rd(8'h00, d);
        chk("R4 set wins new", d, 32'h0000_0200);

        // R9: clearing one word leaves the others
        clear_all();
        step(one_evt(2) | one_evt(34) | one_evt(66), 1'b0, 8'h0, 32'h0);
        step('0, 1'b1, 8'h04, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R9 word0", d, 32'h4);
        rd(8'h04, d); chk("R9 word1", d, 32'h0);
        rd(8'h08, d); chk("R9 word2", d, 32'h4);

        // R5: enable banks read back at their own offsets
        for (int g = 0; g < 3; g++)
            for (int w = 0; w < 3; w++)
                step('0, 1'b1, en_addr(g, w), 32'hA500_0000 | 32'(g * 16 + w));
        for (int g = 0; g < 3; g++)
            for (int w = 0; w < 3; w++) begin
                rd(en_addr(g, w), d);
                chk("R5 readback", d, 32'hA500_0000 | 32'(g * 16 + w));
            end

        // R8: unmapped offsets
        step('0, 1'b1, 8'h0C, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h1C, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h40, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h02, 32'hFFFF_FFFF);
        step('0, 1'b1, 8'h12, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R8 read 0C", d, 32'h0);
        rd(8'h40, d); chk("R8 read 40", d, 32'h0);
        rd(8'h11, d); chk("R8 unaligned", d, 32'h0);
        rd(8'h00, d); chk("R8 status kept", d, 32'h4);
        rd(8'h08, d); chk("R8 status2 kept", d, 32'h4);
        for (int g = 0; g < 3; g++)
            for (int w = 0; w < 3; w++) begin
                rd(en_addr(g, w), d);
                chk("R8 enable kept", d, 32'hA500_0000 | 32'(g * 16 + w));
            end

        // R7: priority moves up as events are acknowledged
        clear_all();
        step('0, 1'b1, en_addr(1, 1), 32'h0000_0102);
        step(one_evt(40) | one_evt(33), 1'b0, 8'h0, 32'h0);
        chk("R7 lowest first", 32'(irq_idx_o[13:7]), 32'd33);
        step('0, 1'b1, 8'h04, 32'h0000_0002);
        chk("R7 next", 32'(irq_idx_o[13:7]), 32'd40);
        chk("R6 still high", 32'(irq_o), 32'b010);
        step('0, 1'b1, 8'h04, 32'h0000_0100);
        chk("R6 drops", 32'(irq_o), 32'h0);
        chk("R7 vld drops", 32'(irq_vld_o), 32'h0);

        // R6: pending but disabled
        step(one_evt(50), 1'b0, 8'h0, 32'h0);
        chk("R6 masked quiet", 32'(irq_o), 32'h0);

        // R1: reset while state is held
        step('0, 1'b1, en_addr(0, 1), 32'hFFFF_FFFF);
        chk("R1 pre-reset line", 32'(irq_o), 32'b001);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset lines", 32'(irq_o), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd(8'h04, d); chk("R1 reset status", d, 32'h0);
        rd(en_addr(0, 1), d); chk("R1 reset enable", d, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule